// File: doc/BRIEF.md
# Word-Triggered Nonvolatile Array Program Controller

This block sits on a simple single-cycle register bus and fronts an on-chip nonvolatile word array. The bus carries a window-select bit. With it low, the access reaches a small set of control registers. With it high, the access reaches the array as 32-bit words on a 4-byte stride. The array has a fixed size, is split into 128-byte pages, and is modelled here as a behavioural register file.

Software first programs a clock divider. The register holds the division factor minus one. Software then selects the word-triggered program mode and clears the power-down bit. After a wake-up delay, a single word write to the array stores the word and starts a timed erase/program cycle with no further command. The length of that cycle is counted in ticks of the divided clock. At the end of the cycle a sticky end-of-program flag is raised, and software clears it by writing a one. Writes that cannot be honoured are dropped and raise a sticky error flag. Such writes include those that arrive during a cycle, before wake-up, outside word mode, or to the top page, which holds initialisation data.

Top module: `nvm_word_prog_ctrl`

## Requirements
- R1: After reset the status register reads 0, the power-down bit reads 1, the divider and mode registers read 0, and `prog_busy` is low.
- R2: The register window decodes these offsets. Mode is at 0x00C, in bits [1:0], and a value of 1 selects word-triggered programming. The divider is at 0x014, in bits [DIV_W-1:0], and the divided clock is the bus clock divided by (divider+1). Power-down is at 0x018, in bit 0, where 1 means off. Status is at 0xFE0, with bit 2 as end-of-program and bit 0 as error. Clear is at 0xFE8 and is write-one-to-clear on bits 2 and 0. Any other offset reads 0. Writes to the status offset have no effect.
- R3: The array becomes usable only after the power-down bit has been 0 for WAKE_CYCLES consecutive bus cycles. Before that, array reads return 0 and array writes are rejected.
- R4: An accepted array write raises `prog_busy` from the next cycle. `prog_busy` stays high for exactly PROG_TICKS*(divider+1) cycles.
- R5: The end-of-program flag is set in the cycle `prog_busy` falls. It stays set until software writes 1 to clear bit 2. If a clear and a completion land in the same cycle, the flag is set.
- R6: Writes to any address at or above MEM_BYTES-PAGE_BYTES are rejected. This covers the top page and anything beyond the array. Top-page word i resets to 0xC0DE0000+i, and all other words reset to 0. The last word below the top page is writable.
- R7: An array write is ignored and sets the sticky error flag (status bit 0) in four cases: a cycle is running, the array is not awake, the mode is not 1, or the address is rejected under R6. The error flag is cleared by writing 1 to clear bit 0.
- R8: An array read returns the stored word in the same bus cycle when the array is awake and idle, ignoring address bits [1:0]. While a cycle runs, an array read returns 0.
- R9: While the power-down bit is 1 during a cycle, the cycle is paused and `prog_busy` stays high. The cycle is lengthened by exactly the number of paused cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_mem | input | 1 | Window select: 1 array, 0 registers |
| bus_addr | input | ADDR_W | Byte address within the selected window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| prog_busy | output | 1 | Erase/program cycle in progress |

## Verification
Two events can coincide on the single bus port. One is the completion of a program cycle, which sets the end-of-program flag. The other is a software write-one-to-clear of that same flag. The bench counts the cycle length from the divider and tick parameters and times a clear so that it reaches the clock edge on which `prog_busy` falls. It then expects the status read to show the flag still set, and expects a second clear to remove it.

// File: rtl/nvm_word_prog_ctrl.sv
module nvm_word_prog_ctrl #(
  parameter int ADDR_W      = 12,
  parameter int DIV_W       = 16,
  parameter int MEM_BYTES   = 512,
  parameter int PAGE_BYTES  = 128,
  parameter int PROG_TICKS  = 4500,
  parameter int WAKE_CYCLES = 4800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic              bus_mem,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              prog_busy
);
  localparam int WORDS     = MEM_BYTES / 4;
  localparam int IDX_W     = $clog2(WORDS);
  localparam int LOCK_BASE = MEM_BYTES - PAGE_BYTES;
  localparam int PCNT_W    = $clog2(PROG_TICKS + 1);
  localparam int WCNT_W    = $clog2(WAKE_CYCLES + 1);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(12'h00C);
  localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(12'h014);
  localparam logic [ADDR_W-1:0] A_PWR  = ADDR_W'(12'h018);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(12'hFE0);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(12'hFE8);

  logic [1:0]        mode_q;
  logic [DIV_W-1:0]  div_q, div_cnt;
  logic              pwrdn_q, eop_q, err_q, busy_q;
  logic [PCNT_W-1:0] prog_cnt;
  logic [WCNT_W-1:0] wake_cnt;
  logic [31:0]       mem [WORDS];

  logic reg_wr, mem_wr, in_range, writable, awake, accept, reject, tick, last_tick, clr_wr;
  logic [IDX_W-1:0] idx;

  assign reg_wr    = bus_valid & bus_write & ~bus_mem;
  assign mem_wr    = bus_valid & bus_write & bus_mem;
  assign clr_wr    = reg_wr & (bus_addr == A_CLR);
  assign idx       = bus_addr[IDX_W+1:2];
  assign in_range  = 32'(bus_addr) < 32'(MEM_BYTES);
  assign writable  = 32'(bus_addr) < 32'(LOCK_BASE);
  assign awake     = ~pwrdn_q & (wake_cnt == WCNT_W'(WAKE_CYCLES));
  assign accept    = mem_wr & awake & ~busy_q & (mode_q == 2'd1) & writable;
  assign reject    = mem_wr & ~accept;
  assign tick      = busy_q & ~pwrdn_q & (div_cnt >= div_q);
  assign last_tick = tick & (prog_cnt == PCNT_W'(PROG_TICKS - 1));
  assign prog_busy = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= '0;
      div_q   <= '0;
      pwrdn_q <= 1'b1;
    end else if (reg_wr) begin
      if (bus_addr == A_MODE) mode_q  <= bus_wdata[1:0];
      if (bus_addr == A_DIV)  div_q   <= bus_wdata[DIV_W-1:0];
      if (bus_addr == A_PWR)  pwrdn_q <= bus_wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || pwrdn_q) wake_cnt <= '0;
    else if (wake_cnt != WCNT_W'(WAKE_CYCLES)) wake_cnt <= wake_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      div_cnt  <= '0;
      prog_cnt <= '0;
    end else if (accept) begin
      busy_q   <= 1'b1;
      div_cnt  <= '0;
      prog_cnt <= '0;
    end else if (busy_q && !pwrdn_q) begin
      if (tick) begin
        div_cnt  <= '0;
        prog_cnt <= prog_cnt + 1'b1;
        if (last_tick) busy_q <= 1'b0;
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eop_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      eop_q <= (eop_q & ~(clr_wr & bus_wdata[2])) | last_tick;
      err_q <= (err_q & ~(clr_wr & bus_wdata[0])) | reject;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++)
        mem[i] <= (i < LOCK_BASE / 4) ? 32'h0 : (32'hC0DE0000 | 32'(i));
    end else if (accept) begin
      mem[idx] <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_valid && !bus_write) begin
      if (bus_mem) begin
        if (awake && !busy_q && in_range) bus_rdata = mem[idx];
      end else begin
        case (bus_addr)
          A_MODE:  bus_rdata[1:0] = mode_q;
          A_DIV:   bus_rdata[DIV_W-1:0] = div_q;
          A_PWR:   bus_rdata[0] = pwrdn_q;
          A_STAT:  begin bus_rdata[2] = eop_q; bus_rdata[0] = err_q; end
          default: bus_rdata = '0;
        endcase
      end
    end
  end

  // R5
  eop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eop_q && !(clr_wr && bus_wdata[2])) |=> eop_q);
  // R5
  eop_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> eop_q);
  // R3
  start_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(awake) && $past(mode_q) == 2'd1);
  // R7
  busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && busy_q) |=> err_q);
  // R9
  pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && pwrdn_q && !accept) |=> $stable(prog_cnt) && busy_q);
endmodule

// File: tb/nvm_word_prog_ctrl_tb.sv
module nvm_word_prog_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12, DIV_W = 16, MEM_BYTES = 512, PAGE_BYTES = 128;
  localparam int PROG_TICKS = 5, WAKE_CYCLES = 10;
  localparam int WORDS = MEM_BYTES / 4;
  localparam int LOCK_BASE = MEM_BYTES - PAGE_BYTES;
  localparam int BUS_HZ = 1000000000 / CLK_PERIOD;

  logic clk = 0, rst_n = 0, bus_valid = 0, bus_write = 0, bus_mem = 0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic prog_busy;
  int runs = 0, fails = 0, cyc = 0;
  logic [31:0] shadow [WORDS];

  nvm_word_prog_ctrl #(.ADDR_W(ADDR_W), .DIV_W(DIV_W), .MEM_BYTES(MEM_BYTES),
    .PAGE_BYTES(PAGE_BYTES), .PROG_TICKS(PROG_TICKS), .WAKE_CYCLES(WAKE_CYCLES)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write), .bus_mem(bus_mem),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .prog_busy(prog_busy));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int prog_len(int d); return PROG_TICKS * (d + 1); endfunction
  function automatic int div_for(int bus_hz, int target_hz);
    return (bus_hz + target_hz - 1) / target_hz - 1;
  endfunction
  function automatic logic [31:0] init_word(int i);
    return (i < LOCK_BASE / 4) ? 32'h0 : (32'hC0DE0000 | 32'(i));
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic mem, int addr, logic [31:0] data);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_mem = mem; bus_addr = ADDR_W'(addr); bus_wdata = data;
    @(posedge clk); #1;
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(logic mem, int addr, output logic [31:0] data);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_mem = mem; bus_addr = ADDR_W'(addr);
    #1 data = bus_rdata;
    @(posedge clk); #1;
    bus_valid = 0;
  endtask

  task automatic wait_idle(input int s, output int dur);
    while (prog_busy) @(negedge clk);
    dur = cyc - s;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; runs++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int s, dur, a, b, d;
    void'($urandom(32'h5EED));
    for (int i = 0; i < WORDS; i++) shadow[i] = init_word(i);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1 reset state
    rd(0, 12'hFE0, v); chk("R1 status", v, 0);
    rd(0, 12'h018, v); chk("R1 pwrdn", v, 1);
    rd(0, 12'h014, v); chk("R1 div", v, 0);
    rd(0, 12'h00C, v); chk("R1 mode", v, 0);
    chk("R1 busy", 32'(prog_busy), 0);

    // R2 register decode and divider band
    d = div_for(BUS_HZ, 1500000);
    wr(0, 12'h014, 32'(d)); rd(0, 12'h014, v); chk("R2 div readback", v, 32'(d));
    chk("R2 div band", 32'((BUS_HZ / (d + 1) >= 800000) && (BUS_HZ / (d + 1) <= 1600000)), 1);
    wr(0, 12'h00C, 32'h1); rd(0, 12'h00C, v); chk("R2 mode readback", v, 1);
    rd(0, 12'h010, v); chk("R2 unmapped", v, 0);
    wr(0, 12'hFE0, 32'hFFFF_FFFF); rd(0, 12'hFE0, v); chk("R2 status write ignored", v, 0);

    // R7 powered down write rejected
    wr(1, 0, 32'h1234_5678); chk("R7 no start when off", 32'(prog_busy), 0);
    rd(0, 12'hFE0, v); chk("R7 err set", v, 1);
    wr(0, 12'hFE8, 32'h1); rd(0, 12'hFE0, v); chk("R7 err cleared", v, 0);

    // R3 wake-up boundary
    wr(0, 12'h018, 0);
    repeat (WAKE_CYCLES - 1) @(posedge clk); #1;
    rd(1, (WORDS - 1) * 4, v); chk("R3 not yet awake", v, 0);
    rd(1, (WORDS - 1) * 4, v); chk("R3 awake read", v, init_word(WORDS - 1));

    // R7 wrong mode
    wr(0, 12'h00C, 32'h2);
    wr(1, 0, 32'hDEAD_0001); chk("R7 mode2 no start", 32'(prog_busy), 0);
    rd(0, 12'hFE0, v); chk("R7 mode2 err", v, 1);
    rd(1, 0, v); chk("R7 mode2 unchanged", v, 0);
    wr(0, 12'hFE8, 32'h5); wr(0, 12'h00C, 32'h1);

    // R4 R8 directed program, busy read, busy reject
    wr(1, 32'h10, 32'hA5A5_0010); s = cyc; shadow[4] = 32'hA5A5_0010;
    rd(1, 32'h10, v); chk("R8 read during busy", v, 0);
    wr(1, 32'h20, 32'hBAD0_0020);
    rd(0, 12'hFE0, v); chk("R7 busy reject err", v, 1);
    wait_idle(s, dur); chk("R4 cycle length", 32'(dur), 32'(prog_len(d)));
    rd(0, 12'hFE0, v); chk("R5 eop set", v, 32'h5);
    wr(0, 12'hFE8, 32'h4); rd(0, 12'hFE0, v); chk("R5 eop cleared only", v, 1);
    wr(0, 12'hFE8, 32'h1);
    rd(1, 32'h13, v); chk("R8 low bits ignored", v, 32'hA5A5_0010);
    rd(1, 32'h20, v); chk("R7 busy write dropped", v, 0);

    // R6 locked top page and last writable word
    wr(1, LOCK_BASE, 32'h0BAD_0BAD); chk("R6 no start", 32'(prog_busy), 0);
    rd(0, 12'hFE0, v); chk("R6 err", v, 1);
    rd(1, LOCK_BASE, v); chk("R6 init kept", v, init_word(LOCK_BASE / 4));
    wr(1, MEM_BYTES + 8, 32'h1); rd(0, 12'hFE0, v); chk("R6 beyond array err", v, 1);
    wr(0, 12'hFE8, 32'h1);
    wr(1, LOCK_BASE - 4, 32'h7777_1234); s = cyc; shadow[LOCK_BASE / 4 - 1] = 32'h7777_1234;
    wait_idle(s, dur);
    rd(1, LOCK_BASE - 4, v); chk("R6 last writable word", v, 32'h7777_1234);
    wr(0, 12'hFE8, 32'h4);

    // R5 collision: clear lands on completion edge
    wr(1, 32'h40, 32'hC011_1DE0); shadow[16] = 32'hC011_1DE0;
    repeat (prog_len(d) - 1) @(posedge clk); #1;
    wr(0, 12'hFE8, 32'h4);
    chk("R5 busy fell at clear edge", 32'(prog_busy), 0);
    rd(0, 12'hFE0, v); chk("R5 set wins over clear", v, 32'h4);
    wr(0, 12'hFE8, 32'h4); rd(0, 12'hFE0, v); chk("R5 second clear", v, 0);

    // R9 pause by power-down
    wr(1, 32'h44, 32'h9A05_E000); s = cyc; shadow[17] = 32'h9A05_E000;
    repeat (20) @(posedge clk); #1;
    wr(0, 12'h018, 1); a = cyc;
    repeat (30) @(posedge clk); #1;
    chk("R9 busy held in pause", 32'(prog_busy), 1);
    wr(0, 12'h018, 0); b = cyc;
    wait_idle(s, dur); chk("R9 extended length", 32'(dur), 32'(prog_len(d) + (b - a)));
    repeat (WAKE_CYCLES + 1) @(posedge clk); #1;
    rd(1, 32'h44, v); chk("R9 data after pause", v, 32'h9A05_E000);
    wr(0, 12'hFE8, 32'h5);

    // R4 small divider
    wr(0, 12'h014, 2);
    wr(1, 32'h48, 32'h0000_0F0F); s = cyc; shadow[18] = 32'h0000_0F0F;
    wait_idle(s, dur); chk("R4 div2 length", 32'(dur), 32'(prog_len(2)));
    wr(0, 12'hFE8, 32'h5);
    wr(0, 12'h014, 32'(d));

    // R4 R6 R8 random writes and reads
    for (int n = 0; n < 14; n++) begin
      int w = $urandom_range(0, WORDS - 1);
      int ad = w * 4 + $urandom_range(0, 3);
      logic [31:0] dv = $urandom;
      wr(1, ad, dv); s = cyc;
      if (w < LOCK_BASE / 4) begin
        shadow[w] = dv;
        wait_idle(s, dur); chk("R4 random length", 32'(dur), 32'(prog_len(d)));
        rd(0, 12'hFE0, v); chk("R5 random eop", v, 32'h4);
      end else begin
        chk("R6 random locked idle", 32'(prog_busy), 0);
        rd(0, 12'hFE0, v); chk("R6 random locked err", v, 32'h1);
      end
      wr(0, 12'hFE8, 32'h5);
      for (int k = 0; k < 3; k++) begin
        int r = $urandom_range(0, WORDS - 1);
        rd(1, r * 4, v); chk("R8 random readback", v, shadow[r]);
      end
    end

    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule